// File: doc/BRIEF.md
# Display Controller Run and Interrupt Control

This block holds the control and status registers of a display controller. Software reaches it through a plain 32-bit register bus: word index 0 is the control register and word index 1 is the status register. It drives one `run` output that tells the pixel datapath whether to fetch and scan out. The timing generator reports frame starts and frame ends as single-cycle pulses.

Software starts the controller by writing the run-enable bit set and the stop-request bit clear in the same write. There are two ways to stop it. A graceful stop sets the stop-request bit. The datapath then keeps running until the next frame-end pulse, so the frame in flight completes. An abrupt stop clears the run-enable bit, and `run` falls on the same edge that captures that write. Each stop path sets its own completion flag. The frame-start and frame-end events also latch flags. Each flag has its own enable bit in the control register, and the enabled flags are combined onto a single interrupt line.

Top module: `disp_ctl`

## Requirements
- R1: After synchronous reset, `run` and `irq` are 0, the control register reads 0x0000_0000 and the status register reads 0x0000_0001.
- R2: A control write with bit 3 (run-enable) at 1 and bit 4 (stop-request) at 0, made while stopped, drives `run` to 1 on the edge that captures the write. Status bit 0 (stopped) then reads 0.
- R3: A control write with bits 3 and 4 both at 1, made while running, starts a graceful stop. `run` stays 1 until a later frame-end pulse and falls on the edge that samples that pulse. At that edge status bit 2 (graceful-stop done) is set and status bit 0 reads 1.
- R4: A frame-end pulse in the same cycle as the write that starts a graceful stop does not end the stop. The next frame-end pulse does.
- R5: A control write with bit 3 at 0, made while running or while a graceful stop is pending, drives `run` to 0 on the edge that captures the write and sets status bit 3 (abrupt-stop done). The same write made while stopped sets no flag.
- R6: While `run` is 1, a frame-start pulse sets status bit 4 and a frame-end pulse sets status bit 5. While `run` is 0, both pulses are ignored.
- R7: A status write of 0 to bits 2 to 5 clears those flags, and a 1 leaves them unchanged. A flag event in the same cycle as its clear wins, so the flag stays set.
- R8: `irq` is a registered OR of four terms. Each term is a flag ANDed with its enable bit: status 2 with control bit 8, status 3 with control bit 7, status 4 with control bit 12, and status 5 with control bit 13.
- R9: Only control bits 3, 4, 7, 8, 12 and 13 are stored, and the other control bits read as 0. Read data is registered: it shows the addressed register as it stood before the edge that samples the address.
- R10: A control write with bit 3 at 1 and bit 4 at 0, made while a graceful stop is pending, cancels the stop. A later frame-end pulse then leaves `run` at 1.
- R11: A control write with bits 3 and 4 both at 1, made while stopped, leaves `run` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index (0 control, 1 status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| frame_start | input | 1 | Frame-start pulse from the timing generator |
| frame_end | input | 1 | Frame-end pulse from the timing generator |
| run | output | 1 | Datapath run enable (registered) |
| irq | output | 1 | Interrupt request (registered) |

## Verification
The bound checker checks the following on every cycle:
- A start write raises `run`.
- An abrupt-stop write drops `run` and sets its done flag.
- `run` holds while no frame-end pulse and no abrupt-stop write arrive.
- Frame flags do not move while stopped.
- `irq` always equals the OR of enabled flags.
- A stop-request write made while stopped never starts the datapath.

Only the bench's scenarios can show the following:
- Which frame-end pulse completes a graceful stop (R4).
- Cancelling a pending stop (R10).
- The set-over-clear priority in the status register.
- The exact readback values of both registers.

// File: rtl/disp_ctl_pkg.sv
package disp_ctl_pkg;
  // Control register bit positions
  localparam int C_RUN_EN   = 3;
  localparam int C_STOP_REQ = 4;
  localparam int C_IE_ABRT  = 7;
  localparam int C_IE_GRACE = 8;
  localparam int C_IE_FST   = 12;
  localparam int C_IE_FEND  = 13;
  // Status register bit positions
  localparam int S_STOPPED  = 0;
  localparam int S_FLAG_LSB = 2;   // flags occupy bits 2..5
  localparam int N_FLAGS    = 4;   // grace-done, abrupt-done, frame-start, frame-end

  localparam logic [31:0] CTRL_MASK = (32'd1 << C_RUN_EN) | (32'd1 << C_STOP_REQ) |
                                      (32'd1 << C_IE_ABRT) | (32'd1 << C_IE_GRACE) |
                                      (32'd1 << C_IE_FST)  | (32'd1 << C_IE_FEND);

  typedef enum logic [1:0] {
    ST_STOPPED = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_DRAIN   = 2'd2
  } run_state_e;
endpackage

// File: rtl/disp_run_fsm.sv
module disp_run_fsm
  import disp_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_nxt,
  input  logic stop_nxt,
  input  logic frame_end,
  output logic run_q,
  output logic grace_done,
  output logic abrupt_done
);
  run_state_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    grace_done  = 1'b0;
    abrupt_done = 1'b0;
    case (st_q)
      ST_STOPPED: if (en_nxt && !stop_nxt) st_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (!en_nxt) begin
          st_d = ST_STOPPED;
          abrupt_done = 1'b1;
        end else if (stop_nxt) begin
          st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!en_nxt) begin
          st_d = ST_STOPPED;
          abrupt_done = 1'b1;
        end else if (!stop_nxt) begin
          st_d = ST_ACTIVE;
        end else if (frame_end) begin
          st_d = ST_STOPPED;
          grace_done = 1'b1;
        end
      end
      default: st_d = ST_STOPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_STOPPED;
      run_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= (st_d != ST_STOPPED);
    end
  end
endmodule

// File: rtl/disp_flag_bank.sv
module disp_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] keep_bits,
  input  logic [N-1:0] en_nxt,
  output logic [N-1:0] flags_q,
  output logic         irq_q
);
  logic [N-1:0] flags_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flags_d[i] = set[i] | (flags_q[i] & ~(clr_wr & ~keep_bits[i]));
    end
    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_d & en_nxt);
  end
endmodule

// File: rtl/disp_ctl.sv
module disp_ctl
  import disp_ctl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CTRL_IDX = 0,
  parameter int STAT_IDX = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic              run,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_IDX);
  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(CTRL_MASK);

  logic [DATA_W-1:0]  ctrl_q, ctrl_d;
  logic               ctrl_wr, stat_wr;
  logic               grace_done, abrupt_done;
  logic [N_FLAGS-1:0] flag_set, flag_keep, flag_en, flag_q;
  logic [DATA_W-1:0]  status;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign ctrl_d  = ctrl_wr ? (bus_wdata & MASK_W) : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  disp_run_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_nxt     (ctrl_d[C_RUN_EN]),
    .stop_nxt   (ctrl_d[C_STOP_REQ]),
    .frame_end  (frame_end),
    .run_q      (run),
    .grace_done (grace_done),
    .abrupt_done(abrupt_done)
  );

  assign flag_set  = {frame_end & run, frame_start & run, abrupt_done, grace_done};
  assign flag_keep = bus_wdata[S_FLAG_LSB +: N_FLAGS];
  assign flag_en   = {ctrl_d[C_IE_FEND], ctrl_d[C_IE_FST], ctrl_d[C_IE_ABRT], ctrl_d[C_IE_GRACE]};

  disp_flag_bank #(.N(N_FLAGS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set      (flag_set),
    .clr_wr   (stat_wr),
    .keep_bits(flag_keep),
    .en_nxt   (flag_en),
    .flags_q  (flag_q),
    .irq_q    (irq)
  );

  always_comb begin
    status = '0;
    status[S_STOPPED] = ~run;
    status[S_FLAG_LSB +: N_FLAGS] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_addr == A_CTRL) bus_rdata <= ctrl_q;
    else if (bus_addr == A_STAT) bus_rdata <= status;
    else                        bus_rdata <= '0;
  end
endmodule

// File: rtl/disp_ctl_chk.sv
module disp_ctl_chk #(
  parameter int ADDR_W   = 4,
  parameter int CTRL_IDX = 0,
  parameter int STAT_IDX = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              w_en,
  input logic              w_stop,
  input logic              frame_end,
  input logic              run,
  input logic              irq,
  input logic [3:0]        flags,
  input logic [3:0]        enables
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_IDX);

  logic cw, sw;
  assign cw = bus_wr && (bus_addr == A_CTRL);
  assign sw = bus_wr && (bus_addr == A_STAT);

  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (cw && w_en && !w_stop && !run) |=> run);

  a_r5_abrupt: assert property (@(posedge clk) disable iff (rst)
    (cw && !w_en && run) |=> (!run && flags[1]));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !frame_end && !(cw && !w_en)) |=> run);

  a_r6_ignore: assert property (@(posedge clk) disable iff (rst)
    (!run && !sw) |=> (flags[3:2] == $past(flags[3:2])));

  a_r8_irq: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & enables));

  a_r11_no_start: assert property (@(posedge clk) disable iff (rst)
    (!run && cw && w_stop) |=> !run);
endmodule

bind disp_ctl disp_ctl_chk #(.ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX), .STAT_IDX(STAT_IDX)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .w_en     (bus_wdata[3]),
  .w_stop   (bus_wdata[4]),
  .frame_end(frame_end),
  .run      (run),
  .irq      (irq),
  .flags    (flag_q),
  .enables  ({ctrl_q[13], ctrl_q[12], ctrl_q[7], ctrl_q[8]})
);

// File: tb/tb_disp_ctl.sv
module tb_disp_ctl;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam logic [AW-1:0] AC = 4'd0;
  localparam logic [AW-1:0] AS = 4'd1;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic run, irq;

  always #(CLK_P/2) clk = ~clk;

  disp_ctl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_start(frame_start), .frame_end(frame_end), .run(run), .irq(irq)
  );

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // Behavioural reference: mode 0 stopped, 1 running, 2 stop pending
  int m_mode = 0;
  logic [31:0] m_ctrl = 0, m_flags = 0, m_rdata = 0;
  logic m_run = 0, m_irq = 0;

  function automatic logic [31:0] m_status();
    return m_flags | {31'd0, (m_mode == 0)};
  endfunction

  always @(posedge clk) begin
    logic [31:0] cn, fl;
    int nm;
    if (rst) begin
      m_mode = 0; m_ctrl = 0; m_flags = 0; m_rdata = 0; m_run = 0; m_irq = 0;
    end else begin
      m_rdata = (bus_addr == AC) ? m_ctrl : (bus_addr == AS) ? m_status() : 32'd0;
      cn = (bus_wr && bus_addr == AC) ? (bus_wdata & 32'h0000_3198) : m_ctrl;
      fl = m_flags;
      if (bus_wr && bus_addr == AS) fl = fl & bus_wdata & 32'h3C;
      if (m_mode != 0 && frame_start) fl[4] = 1'b1;
      if (m_mode != 0 && frame_end)   fl[5] = 1'b1;
      nm = m_mode;
      if (m_mode == 0) begin
        if (cn[3] && !cn[4]) nm = 1;
      end else if (!cn[3]) begin
        nm = 0; fl[3] = 1'b1;
      end else if (m_mode == 1) begin
        if (cn[4]) nm = 2;
      end else begin
        if (!cn[4]) nm = 1;
        else if (frame_end) begin nm = 0; fl[2] = 1'b1; end
      end
      m_mode = nm; m_ctrl = cn; m_flags = fl;
      m_run = (nm != 0);
      m_irq = (fl[2] & cn[8]) | (fl[3] & cn[7]) | (fl[4] & cn[12]) | (fl[5] & cn[13]);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_chk++;
      if (run !== m_run || irq !== m_irq || bus_rdata !== m_rdata) begin
        n_err++;
        $display("FAIL %s cycle compare: run=%0b irq=%0b rdata=%h expected run=%0b irq=%0b rdata=%h",
                 cur_req, run, irq, bus_rdata, m_run, m_irq, m_rdata);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                     input logic s, input logic e);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; frame_start = s; frame_end = e;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0); settle();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin cyc(1'b0, bus_addr, 32'd0, 1'b0, 1'b0); settle(); end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req, input logic [31:0] exp);
    cyc(1'b0, a, 32'd0, 1'b0, 1'b0); settle();
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; cmp_on = 1'b1;
    // R1
    settle();
    chk("R1 run", {31'd0, run}, 0); chk("R1 irq", {31'd0, irq}, 0);
    rd(AC, "R1 ctrl", 32'h0); rd(AS, "R1 status", 32'h1);
    // R9 and R5 (abrupt write while stopped sets nothing)
    cur_req = "R9";
    wr(AC, 32'hFFFF_FFE7);
    rd(AC, "R9 ctrl mask", 32'h0000_3180);
    rd(AS, "R5 no flag while stopped", 32'h1);
    // R2
    cur_req = "R2";
    wr(AC, 32'h3188);
    chk("R2 run", {31'd0, run}, 1);
    rd(AS, "R2 status", 32'h0);
    // R6 / R8
    cur_req = "R6";
    cyc(1'b0, AS, 0, 1'b1, 1'b0); settle();
    chk("R8 irq on sof", {31'd0, irq}, 1);
    rd(AS, "R6 sof flag", 32'h10);
    // R7 clear with zero, keep with one
    cur_req = "R7";
    wr(AS, 32'hFFFF_FFEF);
    chk("R7 irq after clear", {31'd0, irq}, 0);
    rd(AS, "R7 cleared", 32'h0);
    cyc(1'b1, AS, 32'h0, 1'b0, 1'b1); settle();
    rd(AS, "R7 set wins", 32'h20);
    wr(AS, 32'h0);
    // R8 masking
    cur_req = "R8";
    wr(AC, 32'h0008);
    cyc(1'b0, AS, 0, 1'b1, 1'b0); settle();
    chk("R8 masked irq", {31'd0, irq}, 0);
    rd(AS, "R8 flag held", 32'h10);
    wr(AC, 32'h1008);
    chk("R8 unmask irq", {31'd0, irq}, 1);
    wr(AS, 32'h0);
    // R4 and R3 graceful stop
    cur_req = "R4";
    cyc(1'b1, AC, 32'h3198, 1'b0, 1'b1); settle();
    chk("R4 run after same-cycle eof", {31'd0, run}, 1);
    cur_req = "R3";
    idle(3);
    chk("R3 run held", {31'd0, run}, 1);
    cyc(1'b0, AS, 0, 1'b0, 1'b1); settle();
    chk("R3 run falls", {31'd0, run}, 0);
    rd(AS, "R3 status", 32'h25);
    // R6 ignored while stopped
    cur_req = "R6";
    wr(AS, 32'h0);
    cyc(1'b0, AS, 0, 1'b1, 1'b1); settle();
    rd(AS, "R6 ignored stopped", 32'h1);
    chk("R6 irq", {31'd0, irq}, 0);
    // R10 cancel
    cur_req = "R10";
    wr(AC, 32'h3188); wr(AC, 32'h3198); wr(AC, 32'h3188);
    cyc(1'b0, AS, 0, 1'b0, 1'b1); settle();
    chk("R10 still running", {31'd0, run}, 1);
    rd(AS, "R10 status", 32'h20);
    wr(AS, 32'h0);
    // R5 abrupt during pending stop
    cur_req = "R5";
    wr(AC, 32'h3198);
    wr(AC, 32'h3190);
    chk("R5 run drop", {31'd0, run}, 0);
    chk("R5 irq", {31'd0, irq}, 1);
    rd(AS, "R5 status", 32'h9);
    wr(AS, 32'h0);
    // R5 abrupt from running
    wr(AC, 32'h3188);
    wr(AC, 32'h0080);
    chk("R5 run drop2", {31'd0, run}, 0);
    chk("R8 abrupt irq", {31'd0, irq}, 1);
    rd(AS, "R5 status2", 32'h9);
    wr(AS, 32'h0);
    // R11
    cur_req = "R11";
    wr(AC, 32'h0018);
    idle(3);
    chk("R11 no start", {31'd0, run}, 0);
    rd(AS, "R11 status", 32'h1);
    rd(AC, "R11 ctrl", 32'h18);
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule